// File: doc/BRIEF.md
# Serial Transmit Bit Retimer

This block takes a serial bit stream from a host that drives one data line and one strobe line, and hands a single bit to a downstream FSK modulator. The host does not need a UART. A divider inside the block makes a bit tick at a fixed rate (1200 per second by default) from the system clock. The strobe line has two jobs. Its rising edge captures the data line into a holding stage. Its level, sampled at every tick, chooses between two sources for the modulator: the data line passed straight through, or a retimed bit that was moved from the holding stage into a send stage on that tick.

When the strobe is sampled low at a tick, the block pulls its active-low ready flag low to ask for the next bit. The host then presents the bit on the data line and pulses the strobe high and back low before the following tick. Any high strobe level releases the ready flag. If the strobe is held high all the time, the block is a transparent bypass.

Both host lines pass through a synchroniser before any edge detection or sampling. The output source is latched at the tick, so it changes only on tick boundaries.

Top module: `tx_bit_retimer`

## Requirements
- R1: While reset is asserted, `ready_n` is 1 and `mod_bit` is 1 (mark). Reset selects bypass, and the holding and send stages both read 1.
- R2: The bit tick is a one-cycle pulse that repeats every SYS_CLK_HZ / BIT_RATE_HZ system clocks. While the host keeps up, `ready_n` falls exactly that many cycles apart.
- R3: In bypass, `mod_bit` equals `host_txd` as it was SYNC_STAGES (default 2) clock edges earlier.
- R4: Only a rising edge of the synchronised `host_strobe` loads the synchronised `host_txd` into the holding stage. Changing `host_txd` at other times has no effect on the bit sent.
- R5: At each tick, the send stage takes the holding-stage value. With the strobe sampled low at that tick, `mod_bit` shows this value from the cycle after the tick.
- R6: A tick that samples the synchronised strobe low drives `ready_n` to 0 in the next cycle.
- R7: `ready_n` is 1 in every cycle that follows a cycle in which the synchronised strobe was high.
- R8: The output source (bypass or retimed) is latched only at ticks. In retimed mode, `mod_bit` does not change between ticks.
- R9: If a strobe rising edge and a tick fall in the same cycle, the send stage takes the old holding value. The newly captured bit is sent at the following tick.
- R10: A tick that samples the strobe high returns the block to bypass. From then on, `mod_bit` follows `host_txd` as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_txd | input | 1 | Serial data line from the host (asynchronous) |
| host_strobe | input | 1 | Host strobe: rising edge captures data, level selects the mode (asynchronous) |
| mod_bit | output | 1 | Bit presented to the FSK modulator |
| ready_n | output | 1 | Active-low request for the next bit |

## Verification
The in-line properties check the following on every cycle:
- the tick spacing;
- the load of the send stage from the holding stage;
- capture on the strobe edge;
- the set and release of the ready flag;
- that the mode and the retimed output are held between ticks.

Some behaviour can only be shown by the bench scenarios:
- the end-to-end host handshake, where a random bit is loaded per request and appears at the next ready fall;
- bypass latency under random data;
- the collision of a strobe edge with a tick;
- the return to bypass.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic {
    MODE_BYPASS = 1'b0,
    MODE_RETIME = 1'b1
  } out_mode_e;

  // System clocks per bit tick, never below 2.
  function automatic int unsigned ticks_per_bit(int unsigned sys_hz, int unsigned bit_hz);
    int unsigned q;
    q = sys_hz / bit_hz;
    return (q < 2) ? 2 : q;
  endfunction

  // Bits needed to count 0 .. n-1.
  function automatic int unsigned count_bits(int unsigned n);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) < 64'(n)) w++;
    return w;
  endfunction

  // Source select for the modulator input.
  function automatic logic pick_out(out_mode_e m, logic retimed, logic direct);
    return (m == MODE_RETIME) ? retimed : direct;
  endfunction

endpackage

// File: rtl/rt_tick_div.sv
module rt_tick_div #(
  parameter int unsigned PERIOD = 10000
) (
  input  logic clk,
  input  logic rst,
  output logic bit_tick
);
  localparam int unsigned W = rt_pkg::count_bits(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  assign bit_tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (bit_tick) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // Independent spacing counter for the period check.
  logic [W:0] gap;
  always_ff @(posedge clk) begin
    if (rst)           gap <= '0;
    else if (bit_tick) gap <= '0;
    else               gap <= gap + 1'b1;
  end

  p_tick_period_r2: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> (gap == (W+1)'(PERIOD - 1)));

  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);

endmodule

// File: rtl/rt_line_sync.sv
module rt_line_sync #(
  parameter int unsigned       LINES    = 2,
  parameter int unsigned       STAGES   = 2,
  parameter logic [LINES-1:0]  IDLE_LVL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d_in,
  output logic [LINES-1:0] d_out
);
  localparam int unsigned ST = (STAGES < 2) ? 2 : STAGES;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [ST-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= {ST{IDLE_LVL[i]}};
      else     sh <= {sh[ST-2:0], d_in[i]};
    end
    assign d_out[i] = sh[ST-1];
  end

endmodule

// File: rtl/rt_retime_core.sv
module rt_retime_core
  import rt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic txd_s,
  input  logic strobe_s,
  output logic mod_bit,
  output logic ready_n
);
  logic      strobe_q;
  logic      hold_r;
  logic      send_r;
  out_mode_e mode_r;
  logic      cap_evt;

  assign cap_evt = strobe_s & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b1;
      hold_r   <= 1'b1;
      send_r   <= 1'b1;
      mode_r   <= MODE_BYPASS;
      ready_n  <= 1'b1;
    end else begin
      strobe_q <= strobe_s;
      if (cap_evt)  hold_r <= txd_s;
      if (bit_tick) begin
        send_r <= hold_r;
        mode_r <= strobe_s ? MODE_BYPASS : MODE_RETIME;
      end
      if (strobe_s)      ready_n <= 1'b1;
      else if (bit_tick) ready_n <= 1'b0;
    end
  end

  assign mod_bit = pick_out(mode_r, send_r, txd_s);

  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (hold_r == $past(txd_s)));

  p_hold_keep_r4: assert property (@(posedge clk) disable iff (rst)
    !cap_evt |=> $stable(hold_r));

  p_send_load_r5: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> (send_r == $past(hold_r)));

  p_ready_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !strobe_s) |=> !ready_n);

  p_ready_release_r7: assert property (@(posedge clk) disable iff (rst)
    strobe_s |=> ready_n);

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(mode_r));

  p_out_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MODE_RETIME && !bit_tick) |=> $stable(mod_bit));

  p_collide_old_r9: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && cap_evt) |=> (send_r == $past(hold_r) && hold_r == $past(txd_s)));

  p_to_bypass_r10: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && strobe_s) |=> (mode_r == MODE_BYPASS));

endmodule

// File: rtl/tx_bit_retimer.sv
module tx_bit_retimer #(
  parameter int unsigned SYS_CLK_HZ  = 12_000_000,
  parameter int unsigned BIT_RATE_HZ = 1200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic host_txd,
  input  logic host_strobe,
  output logic mod_bit,
  output logic ready_n
);
  localparam int unsigned PERIOD = rt_pkg::ticks_per_bit(SYS_CLK_HZ, BIT_RATE_HZ);

  logic       bit_tick;
  logic [1:0] lines_raw;
  logic [1:0] lines_s;
  logic       txd_s;
  logic       strobe_s;

  assign lines_raw = {host_strobe, host_txd};
  assign txd_s     = lines_s[0];
  assign strobe_s  = lines_s[1];

  rt_tick_div #(.PERIOD(PERIOD)) u_div (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick)
  );

  rt_line_sync #(.LINES(2), .STAGES(SYNC_STAGES), .IDLE_LVL(2'b11)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (lines_raw),
    .d_out (lines_s)
  );

  rt_retime_core u_core (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .txd_s    (txd_s),
    .strobe_s (strobe_s),
    .mod_bit  (mod_bit),
    .ready_n  (ready_n)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ready_n && mod_bit));

endmodule

// File: tb/tx_bit_retimer_test.sv
`timescale 1ns/1ps
module tx_bit_retimer_test;
  localparam int unsigned SYS_HZ  = 48000;
  localparam int unsigned RATE_HZ = 1200;

  function automatic int bit_period(int unsigned sys, int unsigned rate);
    return int'(sys / rate);
  endfunction

  localparam int P   = bit_period(SYS_HZ, RATE_HZ);
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txd = 1'b1;
  logic strobe = 1'b1;
  logic mod_bit, ready_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tx_bit_retimer #(.SYS_CLK_HZ(SYS_HZ), .BIT_RATE_HZ(RATE_HZ), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .host_txd(txd), .host_strobe(strobe),
    .mod_bit(mod_bit), .ready_n(ready_n)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bypass: random data, output must trail the input by LAT edges.
  task automatic bypass_run(string req, int cycles);
    bit [255:0] drv;
    bit ok;
    int first_bad_a, first_bad_e;
    ok = 1'b1; first_bad_a = 0; first_bad_e = 0;
    for (int i = 0; i < cycles; i++) begin
      if (i >= LAT && ok && (mod_bit !== drv[i-LAT])) begin
        ok = 1'b0; first_bad_a = int'(mod_bit); first_bad_e = int'(drv[i-LAT]);
      end
      drv[i] = 1'($urandom % 2);
      txd = drv[i];
      @(negedge clk);
    end
    chk(req, ok ? 1 : first_bad_a, ok ? 1 : first_bad_e);
  endtask

  // Wait for ready_n low; returns negedges waited, checks mod_bit steady meanwhile.
  task automatic wait_ready(input logic steady_val, input int start, output int n, output bit steady_ok);
    n = start;
    steady_ok = 1'b1;
    while (ready_n === 1'b1 && n < 4 * P) begin
      @(negedge clk);
      n++;
      if (ready_n === 1'b1 && mod_bit !== steady_val) steady_ok = 1'b0;
    end
  endtask

  initial begin : main
    int n;
    bit sok;
    logic prev, b, keep_old, fresh;
    void'($urandom(32'd20240611));

    txd = 1'b0; strobe = 1'b1; rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ready_n in reset", int'(ready_n), 1);
    chk("R1 mod_bit in reset", int'(mod_bit), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R3 / R7: strobe held high, pure pass-through across several ticks
    bypass_run("R3 bypass latency", 3 * P);
    chk("R7 ready_n stays high in bypass", int'(ready_n), 1);

    // Enter retimed mode
    txd = 1'b1; strobe = 1'b0;
    n = 0;
    while (ready_n === 1'b1 && n < 4 * P) begin @(negedge clk); n++; end
    chk("R6 ready_n falls with strobe low", int'(ready_n), 0);
    chk("R5 first retimed bit is reset mark", int'(mod_bit), 1);
    prev = 1'b1;

    for (int k = 0; k < 24; k++) begin
      b = 1'($urandom % 2);
      txd = b; strobe = 1'b1;
      n = 0; sok = 1'b1;
      repeat (4) begin
        @(negedge clk); n++;
        if (mod_bit !== prev) sok = 1'b0;
      end
      chk("R7 ready_n released by strobe", int'(ready_n), 1);
      strobe = 1'b0;
      txd = ~b;                       // R4: late data change must not be sent
      wait_ready(prev, n, n, sok);
      chk("R8 retimed output steady between ticks", int'(sok), 1);
      chk("R2 R6 request spacing", n, P);
      chk("R4 R5 captured bit sent at tick", int'(mod_bit), int'(b));
      prev = b;
    end

    // R9: strobe edge lands on the tick cycle
    keep_old = prev;
    fresh = ~keep_old;
    repeat (P - 3) @(negedge clk);
    txd = fresh; strobe = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    txd = keep_old;
    n = P + 1;
    wait_ready(1'b0, n, n, sok);
    chk("R9 collision request spacing", n, 2 * P);
    chk("R9 bit captured on tick cycle sent next tick", int'(mod_bit), int'(fresh));

    // R10: back to bypass
    strobe = 1'b1;
    repeat (P + 5) @(negedge clk);
    chk("R10 ready_n high after exit", int'(ready_n), 1);
    bypass_run("R10 bypass after exit", 2 * P);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule